// File: doc/BRIEF.md
# Supply Brownout Reset Sequencer

This block turns a digital "supply below threshold" flag, produced by an external analog comparator, into a clean system reset. The flag crosses into the local clock domain through a two-flop synchroniser. A dip filter then rejects low pulses too short to matter. A dip that lasts long enough forces the reset on. Once the supply flag clears, the reset stays on for a programmable hold timeout before the system is allowed to run.

The filter length and the hold timeout are cycle-count parameters. The defaults match roughly 20 µs and 240 ms at a 100 MHz clock, and simulation can use short values. A parameter picks the polarity of the reset output. A status output tells whether the block is still holding the system in reset or has let it run. The reset is on from the moment the block's own power-on reset is applied. If a further qualified dip arrives while the hold timeout is running, the timeout starts over.

Top module: `brownout_reset_seq`

## Requirements
- R1: While rst_ni is low, and after it rises until the first complete hold timeout has run, the reset output is asserted. With below_i low throughout, it releases exactly HOLD_CYCLES+3 clock edges after rst_ni rises.
- R2: below_i passes through two synchroniser flops. From the running phase, a sustained rise of below_i asserts reset on the DIP_CYCLES+3rd rising edge after the change, and not before.
- R3: A below_i pulse that lasts DIP_CYCLES-1 cycles, seen from the running phase, never asserts reset. A pulse that lasts exactly DIP_CYCLES cycles does assert it.
- R4: After a qualified dip in which below_i stayed high for more than DIP_CYCLES cycles, reset releases exactly HOLD_CYCLES+3 edges after below_i falls.
- R5: A dip of more than DIP_CYCLES cycles during the hold timeout restarts it. Reset then releases HOLD_CYCLES+3 edges after that dip ends.
- R6: A dip of DIP_CYCLES-1 cycles during the hold timeout does not change the release edge.
- R7: With ACTIVE_HIGH=1, sys_rst_o is 1 while reset is asserted. With ACTIVE_HIGH=0, it is 0 while reset is asserted. The timing is the same for both.
- R8: hold_o is 1 while reset is asserted (supply low or timeout running) and 0 in the running phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| below_i | input | 1 | Comparator flag, 1 = supply below threshold, asynchronous |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| hold_o | output | 1 | 1 = reset-hold phase, 0 = running phase |

## Verification
The assertions treat below_i as a level that has already been debounced at the comparator, so each change counts as one transition that the synchroniser settles within two edges. They also rely on HOLD_CYCLES being at least 2 and DIP_CYCLES at least 1. The stimulus changes below_i only on falling clock edges, one transition at a time. Each dip it applies is held for a whole number of cycles, so every release and assertion edge is determined exactly.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    ST_LOW  = 2'd0,  // supply flagged low
    ST_HOLD = 2'd1,  // supply good, timeout running
    ST_RUN  = 2'd2
  } brs_state_e;
endpackage

// File: rtl/brs_sync.sv
module brs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= {STAGES{RST_VAL}};
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/brs_dip_filter.sv
module brs_dip_filter #(
  parameter int DIP_CYCLES = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,   // synchronised
  output logic dip_o
);
  localparam int DW = $clog2(DIP_CYCLES + 1);
  localparam logic [DW-1:0] LIMIT = DW'(DIP_CYCLES);

  logic [DW-1:0] cnt;

  // saturating run-length of consecutive low-supply cycles
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt <= LIMIT;
    else if (!below_i)    cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;

  assign dip_o = (cnt == LIMIT);

  AST_QUAL_FROM_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dip_o) |-> $past(below_i)) else $error("qualified without low flag"); // R3
endmodule

// File: rtl/brs_hold_timer.sv
module brs_hold_timer #(
  parameter int HOLD_CYCLES = 24_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int TW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(HOLD_CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          cnt <= '0;
    else if (start_i)     cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;

  assign done_o = (cnt == LAST);

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o) else $error("timer done right after start"); // R5
endmodule

// File: rtl/brownout_reset_seq.sv
module brownout_reset_seq
  import brs_pkg::*;
#(
  parameter int DIP_CYCLES  = 2000,        // ~20 us at 100 MHz
  parameter int HOLD_CYCLES = 24_000_000,  // ~240 ms at 100 MHz, >= 2
  parameter bit ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic below_i,
  output logic sys_rst_o,
  output logic hold_o
);
  logic below_s, dip_q, hold_done, tmr_start;
  brs_state_e state, state_nx;

  brs_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(below_i), .q_o(below_s)
  );

  brs_dip_filter #(.DIP_CYCLES(DIP_CYCLES)) u_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .below_i(below_s), .dip_o(dip_q)
  );

  brs_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tmr_start), .done_o(hold_done)
  );

  always_comb begin
    state_nx  = state;
    tmr_start = 1'b0;
    unique case (state)
      ST_LOW: if (!below_s) begin
        state_nx  = ST_HOLD;
        tmr_start = 1'b1;
      end
      ST_HOLD: begin
        if (dip_q)          state_nx = ST_LOW;  // qualified dip restarts timeout
        else if (hold_done) state_nx = ST_RUN;
      end
      ST_RUN:  if (dip_q) state_nx = ST_LOW;
      default: state_nx = ST_LOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state <= ST_LOW;
    else         state <= state_nx;

  logic rst_on;
  assign rst_on = (state != ST_RUN);

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign sys_rst_o = rst_on;
    end else begin : g_lo
      assign sys_rst_o = ~rst_on;
    end
  endgenerate

  assign hold_o = rst_on;

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_HOLD && !hold_done) |=> state != ST_RUN) else $error("early release"); // R4
  AST_DIP_FORCES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dip_q && state != ST_LOW) |=> state == ST_LOW) else $error("dip missed"); // R2
  AST_LOW_EXITS_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_LOW) |=> state != ST_RUN) else $error("skipped hold"); // R1
  AST_STATUS_AGREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o == (ACTIVE_HIGH ? sys_rst_o : !sys_rst_o)) else $error("status mismatch"); // R8
endmodule

// File: tb/brownout_reset_seq_test.sv
module brownout_reset_seq_test;
  localparam int D = 6;
  localparam int H = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic below = 1'b0;
  logic rst_lo, hold_lo, rst_hi, hold_hi;
  int   checks = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  brownout_reset_seq #(.DIP_CYCLES(D), .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .below_i(below), .sys_rst_o(rst_lo), .hold_o(hold_lo)
  );
  brownout_reset_seq #(.DIP_CYCLES(D), .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b1)) uut_hi (
    .clk_i(clk), .rst_ni(rst_ni), .below_i(below), .sys_rst_o(rst_hi), .hold_o(hold_hi)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // asserted = reset expected on; checks both polarities and status
  task automatic chk_rst(input string tag, input logic asserted);
    chk({tag, " R7 low-polarity"}, rst_lo, ~asserted);
    chk({tag, " R7 high-polarity"}, rst_hi, asserted);
    chk({tag, " R8 status"}, hold_lo, asserted);
  endtask

  task automatic recover();
    below = 1'b0;
    step(H + 10);
    chk_rst("recover", 1'b0);
  endtask

  task automatic t_powerup();
    step(3);
    chk_rst("R1 in por", 1'b1);
    rst_ni = 1'b1;
    step(H + 2);
    chk_rst("R1 before release", 1'b1);
    step(1);
    chk_rst("R1 release", 1'b0);
  endtask

  task automatic t_assert_latency();
    below = 1'b1;
    step(D + 2);
    chk_rst("R2 before assert", 1'b0);
    step(1);
    chk_rst("R2 assert edge", 1'b1);
    step(4);
    below = 1'b0;
    step(H + 2);
    chk_rst("R4 before release", 1'b1);
    step(1);
    chk_rst("R4 release edge", 1'b0);
  endtask

  task automatic t_short_dip();
    below = 1'b1;
    step(D - 1);
    below = 1'b0;
    for (int i = 0; i < D + 6; i++) begin
      step(1);
      chk_rst("R3 short dip ignored", 1'b0);
    end
  endtask

  task automatic t_exact_dip();
    below = 1'b1;
    step(D);
    below = 1'b0;
    step(3);
    chk_rst("R3 exact dip asserts", 1'b1);
    recover();
  endtask

  task automatic t_restart_in_hold();
    below = 1'b1;
    step(D + 4);
    below = 1'b0;
    step(3 + 8);
    chk_rst("R5 mid hold", 1'b1);
    below = 1'b1;
    step(D + 4);
    below = 1'b0;
    step(H + 2);
    chk_rst("R5 restarted hold", 1'b1);
    step(1);
    chk_rst("R5 release after restart", 1'b0);
  endtask

  task automatic t_short_in_hold();
    below = 1'b1;
    step(D + 4);
    below = 1'b0;
    step(5);
    below = 1'b1;
    step(D - 1);
    below = 1'b0;
    step(H + 2 - 5 - (D - 1));
    chk_rst("R6 before release", 1'b1);
    step(1);
    chk_rst("R6 release unchanged", 1'b0);
  endtask

  initial begin
    step(400_000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    t_powerup();
    t_assert_latency();
    t_short_dip();
    t_exact_dip();
    t_restart_in_hold();
    t_short_in_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule